// File: doc/BRIEF.md
# Double-Buffered Serial Frame Transmitter

This block turns words written by software into asynchronous serial frames on a single output line. A frame opens with a low start bit. The 8 or 9 data bits follow, least significant first, and a high stop bit closes it. Every bit lasts a fixed number of baud ticks, and the baud ticks come from an external divider. In front of the shift register sits a one-word holding stage. Software can therefore queue the next word while the current one is still on the line, and consecutive frames go out back to back.

Software talks to the block through a small register port. The port has a status register (buffer-empty and transmission-complete flags), a data register and a control register. The control register holds transmit enable, word length, the ninth data bit, send-break and the two interrupt enables. There is no back-pressure. A data write is accepted in any cycle, and software paces itself on the buffer-empty flag. A data write that reaches a full holding stage overwrites it. Enabling the transmitter first sends a full-length idle frame. Holding send-break emits break frames. A single interrupt line combines the two flags with their enables and a global mask input.

Top module: `txs_top`

## Requirements
- R1: After reset the line is high, the irq output is low, status reads 0x03 and control reads 0x00. Register addresses are 0 for status, 1 for data and 2 for control. In status, bit0 is buffer-empty and bit1 is transmission-complete. In control, bit0 is enable, bit1 is 9-bit mode, bit2 is the ninth bit, bit3 is break, bit4 is the buffer-empty interrupt enable and bit5 is the complete interrupt enable.
- R2: With bit1 of control clear, a frame is one low start bit, then 8 data bits sent LSB first, then one high stop bit. Each bit lasts 16 baud ticks.
- R3: With bit1 of control set, the frame carries 9 data bits. The ninth bit comes from control bit2 and goes out after data bit 7, just before the stop bit.
- R4: When enable rises, an all-ones idle frame the length of a data frame (10 or 11 bits) is sent before any data.
- R5: A data write made while a frame is on the line is held. It starts right after that frame ends, and buffer-empty is set when it moves into the shift register.
- R6: A data write made while the transmitter is enabled, idle and has nothing pending starts a frame at once and leaves buffer-empty set.
- R7: Both flags clear only when a status read is followed by a data write. A data write with no status read since the last data write leaves the flags unchanged.
- R8: While control bit3 is set and the transmitter is enabled and idle, break frames are sent. Each break drives the line low for the frame length (160 ticks in 8-bit mode, 176 in 9-bit mode) and then high for one stop bit.
- R9: Transmission-complete is set when any frame, whether data, idle or break, finishes on the line.
- R10: irq is high exactly when the mask input is low and either buffer-empty is set with bit4 set or transmission-complete is set with bit5 set.
- R11: Clearing enable lets the frame in progress finish, and the line then stays high. Data writes made while the transmitter is disabled are discarded and are not sent after a later enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit period |
| irq_mask | input | 1 | Global interrupt mask, high blocks irq |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational on reg_addr) |
| txd | output | 1 | Serial output line |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the flag behaviour when the holding stage and the shift register are both occupied. This covers a second data write that arrives with no status read in between, and a held word that moves into the shift register in the same cycle a frame ends. The bench reaches it with a direct write immediately followed by a second unarmed write, and watches the interrupt line to see whether buffer-empty survived. Full 8-bit sweeps and partial 9-bit sweeps then keep the holding stage full through polled, back-to-back writes, so every handover lands on a frame boundary.

// File: rtl/txs_pkg.sv
`timescale 1ns/1ps
package txs_pkg;
  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam int CTRL_W = 6;

  typedef struct packed {
    logic tc_ie;
    logic txe_ie;
    logic brk;
    logic ninth;
    logic wide;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/txs_regs.sv
`timescale 1ns/1ps
module txs_regs
  import txs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              frame_end,
  input  logic              txe_set,
  input  logic              irq_mask,
  output ctrl_t             ctrl,
  output logic              txe,
  output logic              tc,
  output logic              armed,
  output logic              data_wr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  assign data_wr = reg_wr && (reg_addr == ADDR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      txe   <= 1'b1;
      tc    <= 1'b1;
      armed <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (reg_rd && reg_addr == ADDR_STAT) armed <= 1'b1;
      else if (data_wr)                    armed <= 1'b0;
      if (data_wr && armed) begin
        txe <= 1'b0;
        tc  <= 1'b0;
      end
      if (txe_set)   txe <= 1'b1;
      if (frame_end) tc  <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_STAT: reg_rdata = {{(DATA_W-2){1'b0}}, tc, txe};
      ADDR_CTRL: reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = !irq_mask && ((txe && ctrl.txe_ie) || (tc && ctrl.tc_ie));
endmodule

// File: rtl/txs_shifter.sv
`timescale 1ns/1ps
module txs_shifter #(
  parameter int SRW   = 12,
  parameter int TICKS = 16,
  localparam int LW   = $clog2(SRW + 1),
  localparam int CW   = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           load,
  input  logic [SRW-1:0] pat,
  input  logic [LW-1:0]  len,
  output logic           txd,
  output logic           busy,
  output logic           frame_end
);
  logic [SRW-1:0] sr;
  logic [LW-1:0]  left;
  logic [CW-1:0]  cnt;
  logic           bit_done;

  assign busy      = (left != '0);
  assign bit_done  = busy && tick && (cnt == CW'(TICKS - 1));
  assign frame_end = bit_done && (left == LW'(1));
  assign txd       = sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '1;
      left <= '0;
      cnt  <= '0;
    end else if (load) begin
      sr   <= pat;
      left <= len;
      cnt  <= '0;
    end else if (bit_done) begin
      sr   <= {1'b1, sr[SRW-1:1]};
      left <= left - LW'(1);
      cnt  <= '0;
    end else if (busy && tick) begin
      cnt  <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/txs_top.sv
`timescale 1ns/1ps
module txs_top
  import txs_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              irq_mask,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              txd,
  output logic              irq
);
  localparam int SRW = DATA_W + 4;
  localparam int LW  = $clog2(SRW + 1);

  ctrl_t             ctrl;
  logic              txe, tc, armed, data_wr;
  logic              busy, frame_end, load, txe_set;
  logic              en_q, pend_idle, hold_vld;
  logic [DATA_W-1:0] hold_q;
  logic              direct, start_idle, start_hold, start_brk;
  logic [LW-1:0]     flen, ld_len;
  logic [SRW-1:0]    ld_pat;

  function automatic logic [SRW-1:0] data_pat(input logic [DATA_W-1:0] d,
                                              input logic nb, input logic w);
    logic [SRW-1:0] p;
    p            = '1;
    p[0]         = 1'b0;
    p[DATA_W:1]  = d;
    if (w) p[DATA_W+1] = nb;
    return p;
  endfunction

  txs_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .frame_end(frame_end),
    .txe_set(txe_set), .irq_mask(irq_mask), .ctrl(ctrl), .txe(txe), .tc(tc),
    .armed(armed), .data_wr(data_wr), .reg_rdata(reg_rdata), .irq(irq)
  );

  txs_shifter #(.SRW(SRW), .TICKS(TICKS_PER_BIT)) shift_i (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(load), .pat(ld_pat),
    .len(ld_len), .txd(txd), .busy(busy), .frame_end(frame_end)
  );

  assign flen       = ctrl.wide ? LW'(DATA_W + 3) : LW'(DATA_W + 2);
  assign direct     = data_wr && ctrl.en && !busy && !pend_idle && !hold_vld;
  assign start_idle = !busy && ctrl.en && pend_idle;
  assign start_hold = !busy && ctrl.en && !pend_idle && hold_vld;
  assign start_brk  = !busy && ctrl.en && !pend_idle && !hold_vld && !data_wr && ctrl.brk;
  assign load       = direct || start_idle || start_hold || start_brk;
  assign txe_set    = direct || start_hold;

  always_comb begin
    ld_pat = '1;
    ld_len = flen;
    if (direct)          ld_pat = data_pat(reg_wdata, ctrl.ninth, ctrl.wide);
    else if (start_hold) ld_pat = data_pat(hold_q, ctrl.ninth, ctrl.wide);
    else if (start_brk) begin
      ld_pat = {SRW{1'b1}} << flen;
      ld_len = flen + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      pend_idle <= 1'b0;
      hold_vld  <= 1'b0;
      hold_q    <= '0;
    end else begin
      en_q <= ctrl.en;
      if (!ctrl.en)        pend_idle <= 1'b0;
      else if (!en_q)      pend_idle <= 1'b1;
      else if (start_idle) pend_idle <= 1'b0;
      if (data_wr && ctrl.en && !direct) begin
        hold_q   <= reg_wdata;
        hold_vld <= 1'b1;
      end else if (start_hold) begin
        hold_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txs_checker.sv
`timescale 1ns/1ps
module txs_checker (
  input logic clk,
  input logic rst_n,
  input logic irq_mask,
  input logic irq,
  input logic txd,
  input logic busy,
  input logic frame_end,
  input logic txe,
  input logic tc,
  input logic armed,
  input logic data_wr,
  input logic tx_en,
  input logic pend_idle,
  input logic hold_vld
);
  assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);

  assert_line_rests_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_tc_from_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> $past(frame_end));

  assert_direct_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_en && !busy && !pend_idle && !hold_vld) |=> (txe && busy));

  assert_armed_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && armed && busy && !frame_end) |=> (!txe && !tc));

  assert_hold_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_en && busy) |=> hold_vld);
endmodule

bind txs_top txs_checker chk_i (
  .clk(clk), .rst_n(rst_n), .irq_mask(irq_mask), .irq(irq), .txd(txd),
  .busy(busy), .frame_end(frame_end), .txe(txe), .tc(tc), .armed(armed),
  .data_wr(data_wr), .tx_en(ctrl.en), .pend_idle(pend_idle), .hold_vld(hold_vld)
);

// File: tb/txs_top_tb_top.sv
`timescale 1ns/1ps
module txs_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_mask = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       txd, irq;
  int         nchk = 0, nfail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  txs_top dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .irq_mask(irq_mask),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .txd(txd), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rx(input int nbits, output logic [8:0] w, output bit ok);
    bit st;
    w = '0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (8) @(negedge clk);
    st = (txd == 1'b0);
    for (int i = 0; i < nbits; i++) begin
      repeat (16) @(negedge clk);
      w[i] = txd;
    end
    repeat (16) @(negedge clk);
    ok = st && (txd == 1'b1);
  endtask

  task automatic count_low(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd == 1'b0) n++;
    end
  endtask

  task automatic sweep(input int nw, input int step, input bit wide, input bit nb,
                       input string tag);
    fork
      begin
        logic [7:0] s;
        for (int k = 0; k < nw; k++) begin
          s = 8'h00;
          while (!s[0]) rd(2'd0, s);
          wr(2'd1, 8'(k * step));
        end
      end
      begin
        logic [8:0] w;
        bit ok;
        for (int k = 0; k < nw; k++) begin
          rx(wide ? 9 : 8, w, ok);
          chk(tag, {ok, w}, {1'b1, wide ? nb : 1'b0, 8'(k * step)});
        end
      end
    join
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    logic [8:0] w;
    bit ok;
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", txd, 1);
    chk("R1 irq", irq, 0);
    rd(2'd0, s); chk("R1 status", s, 8'h03);
    rd(2'd2, s); chk("R1 ctrl", s, 8'h00);
    // R10 interrupt gating
    wr(2'd2, 8'h10); chk("R10 txe_ie", irq, 1);
    irq_mask = 1'b1; @(negedge clk); chk("R10 masked", irq, 0);
    irq_mask = 1'b0;
    wr(2'd2, 8'h20); chk("R10 tc_ie", irq, 1);
    wr(2'd2, 8'h00); chk("R10 none", irq, 0);
    // R11 write while disabled is discarded
    wr(2'd1, 8'h5A);
    count_low(300, n); chk("R11 disabled write", n, 0);
    // R4 idle preamble before first word
    wr(2'd2, 8'h01);
    n = 0;
    fork
      begin rd(2'd0, s); wr(2'd1, 8'hA5); end
      begin
        while (txd == 1'b1 && n < 1000) begin @(negedge clk); n++; end
      end
    join
    chk("R4 preamble length", (n >= 158 && n <= 166), 1);
    rx(8, w, ok); chk("R2 first word", {ok, w}, {1'b1, 9'h0A5});
    repeat (20) @(negedge clk);
    // R2/R5 exhaustive 8-bit sweep, back to back through the holding stage
    sweep(256, 1, 1'b0, 1'b0, "R2_R5 sweep8");
    // R6/R7/R9 flag sequencing
    wr(2'd2, 8'h11);
    fork
      begin
        rd(2'd0, s);
        wr(2'd1, 8'h3C);
        chk("R6 direct load keeps txe", irq, 1);
        wr(2'd1, 8'hC3);
        chk("R7 unarmed write keeps txe", irq, 1);
        repeat (170) @(negedge clk);
        rd(2'd0, s); chk("R9_R5 flags after frame", s, 8'h03);
        wr(2'd1, 8'h81);
        rd(2'd0, s); chk("R7 armed clear", s, 8'h00);
      end
      begin
        rx(8, w, ok); chk("R6 word1", {ok, w}, {1'b1, 9'h03C});
        rx(8, w, ok); chk("R5 word2", {ok, w}, {1'b1, 9'h0C3});
        rx(8, w, ok); chk("R7 word3", {ok, w}, {1'b1, 9'h081});
      end
    join
    repeat (20) @(negedge clk);
    // R3 9-bit sweeps with both ninth-bit values
    wr(2'd2, 8'h03);
    sweep(64, 4, 1'b1, 1'b0, "R3 sweep9 n0");
    wr(2'd2, 8'h07);
    sweep(64, 4, 1'b1, 1'b1, "R3 sweep9 n1");
    // R8 break frames in both word lengths
    for (int m = 0; m < 2; m++) begin
      wr(2'd2, m ? 8'h0B : 8'h09);
      n = 0;
      fork
        begin
          while (txd !== 1'b0) @(negedge clk);
          while (txd == 1'b0 && n < 1000) begin n++; @(negedge clk); end
        end
        begin
          while (txd !== 1'b0) @(negedge clk);
          repeat (30) @(negedge clk);
          wr(2'd2, m ? 8'h03 : 8'h01);
        end
      join
      chk(m ? "R8 break9 length" : "R8 break8 length", n, m ? 176 : 160);
      repeat (20) @(negedge clk);
      rd(2'd0, s); chk("R9 tc after break", s[1], 1);
      count_low(50, n); chk("R8 single break", n, 0);
    end
    // R11 disable mid-frame, then discard while disabled
    wr(2'd2, 8'h01);
    rd(2'd0, s); wr(2'd1, 8'h96);
    fork
      begin rx(8, w, ok); chk("R11 frame completes", {ok, w}, {1'b1, 9'h096}); end
      begin repeat (40) @(negedge clk); wr(2'd2, 8'h00); end
    join
    count_low(300, n); chk("R11 idle after disable", n, 0);
    wr(2'd1, 8'h77);
    wr(2'd2, 8'h01);
    count_low(500, n); chk("R11 discarded after enable", n, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule